// File: doc/BRIEF.md
# Shadowed SRAM with Software Store and Recall

This block is a byte-wide static RAM in which every word has a shadow copy held in a second, nonvolatile-style register array. In normal operation it is a plain SRAM, clocked by a system clock, with select, output-enable and write-enable controls. Software moves the whole working array into the shadow (STORE), or brings the shadow back into the working array (RECALL), by reading six fixed addresses in a row. No dedicated command pin or register is involved.

A watcher follows the stream of accepted accesses. Five shared key addresses must be read in order, and the sixth read picks the operation. While a transfer runs, `busy` is high and host accesses have no effect. A RECALL first clears every word to zero and then loads the shadow word by word. It never writes the shadow. A power-up reset leaves the shadow untouched and, on release, runs a RECALL before the first host access is accepted.

The transfer controller is a state machine with four states:
- XF_IDLE: serves host accesses. It goes to XF_STORE on a completed STORE sequence and to XF_CLEAR on a completed RECALL sequence.
- XF_STORE: copies one word per clock into the shadow. It returns to XF_IDLE after the last word.
- XF_CLEAR: zeroes one word per clock. It goes to XF_LOAD after the last word.
- XF_LOAD: copies one shadow word per clock into the SRAM. It returns to XF_IDLE after the last word.

While `por_n` is low, the controller is held in XF_CLEAR at word 0.

Top module: `nvs_shadow_ram`

## Requirements
- R1: In idle, a cycle with `cs`=1 and `we`=1 writes `din` to word `addr mod DEPTH`. A cycle with `cs`=1, `we`=0 and `oe`=1 puts that word on `dout` with `dout_en`=1 in the following cycle. Addresses that differ only above the low DEPTH_LOG2 bits reach the same word.
- R2: `dout_en` is 0 and `dout` is zero in any cycle that does not follow an accepted read with `oe`=1.
- R3: Six consecutive accepted reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0FC0 start a STORE. `busy` rises in the cycle after the sixth read and stays high for exactly DEPTH cycles.
- R4: The same five reads followed by a read at 0x0C63 start a RECALL. `busy` stays high for exactly 2*DEPTH cycles, and afterwards every SRAM word equals its shadow word.
- R5: A write, or a read whose address is not the next key, aborts the sequence. The next read must then be the first key; the mismatching read itself is not taken as a first key. An aborted sequence starts no transfer.
- R6: Cycles with `cs`=0 neither advance nor abort the sequence.
- R7: While `busy` is high, writes change nothing, reads give `dout_en`=0, and reads do not advance the sequence.
- R8: A RECALL leaves the shadow unchanged, so repeated RECALLs always give the same contents.
- R9: While `por_n` is low, `busy` is 1 and `dout_en` is 0. After release, a RECALL of 2*DEPTH cycles runs automatically, and the shadow written before the reset is preserved.
- R10: A STORE copies every SRAM word into the shadow.
- R11: If the sixth read of a sequence is at neither selector address, no transfer starts and matching restarts from the first key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up reset, active low; release triggers a RECALL |
| cs | input | 1 | Chip select, active high |
| oe | input | 1 | Output enable for reads |
| we | input | 1 | Write enable (1 = write, 0 = read) |
| addr | input | ADDR_W (15) | Word address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` carries read data |
| busy | output | 1 | High while a STORE or RECALL runs |

## Verification
The bench builds the block with DEPTH_LOG2=5, which gives a 32-word array, and keeps ADDR_W=15 so the full-width key addresses are compared. With 32 words, every STORE, RECALL and power-up RECALL can be timed cycle by cycle and read back word by word. The aliasing of upper address bits onto the small array can also be exercised. The short transfers leave room for accesses and a complete unlock sequence inside one busy window, which tests that busy traffic is ignored.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_STORE = 2'd1,
        XF_CLEAR = 2'd2,
        XF_LOAD  = 2'd3
    } xfer_state_t;

    localparam int KEY_LEN = 6;
endpackage

// File: rtl/nvs_key_watch.sv
module nvs_key_watch #(
    parameter int              ADDR_W   = 15,
    parameter logic [14:0]     KEY0     = 15'h0E38,
    parameter logic [14:0]     KEY1     = 15'h31C7,
    parameter logic [14:0]     KEY2     = 15'h03E0,
    parameter logic [14:0]     KEY3     = 15'h3C1F,
    parameter logic [14:0]     KEY4     = 15'h303F,
    parameter logic [14:0]     STORE_K  = 15'h0FC0,
    parameter logic [14:0]     RECALL_K = 15'h0C63
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              cs,
    input  logic              we,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    output logic              go_store,
    output logic              go_recall
);
    localparam int IW = $clog2(nvs_pkg::KEY_LEN);
    localparam logic [IW-1:0] LAST_IDX = IW'(nvs_pkg::KEY_LEN - 1);

    logic [IW-1:0] idx_q;
    logic          acc, rd_acc;

    function automatic logic [ADDR_W-1:0] key_at(input logic [IW-1:0] i);
        case (i)
            IW'(0):  key_at = ADDR_W'(KEY0);
            IW'(1):  key_at = ADDR_W'(KEY1);
            IW'(2):  key_at = ADDR_W'(KEY2);
            IW'(3):  key_at = ADDR_W'(KEY3);
            default: key_at = ADDR_W'(KEY4);
        endcase
    endfunction

    assign acc    = cs && !busy;
    assign rd_acc = acc && !we;

    always_ff @(posedge clk) begin
        if (!por_n) begin
            idx_q <= '0;
        end else if (acc) begin
            if (we || idx_q == LAST_IDX)
                idx_q <= '0;
            else if (addr == key_at(idx_q))
                idx_q <= idx_q + 1'b1;
            else
                idx_q <= '0;
        end
    end

    assign go_store  = rd_acc && (idx_q == LAST_IDX) && (addr == ADDR_W'(STORE_K));
    assign go_recall = rd_acc && (idx_q == LAST_IDX) && (addr == ADDR_W'(RECALL_K));

    assert_write_aborts_R5: assert property (@(posedge clk) disable iff (!por_n)
        (cs && we && !busy) |=> (idx_q == '0));
    assert_deselect_holds_R6: assert property (@(posedge clk) disable iff (!por_n)
        (!cs && !busy) |=> $stable(idx_q));
    assert_busy_freezes_R7: assert property (@(posedge clk) disable iff (!por_n)
        busy |=> $stable(idx_q));
    assert_one_command_R3: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({go_store, go_recall}));
endmodule

// File: rtl/nvs_xfer_fsm.sv
module nvs_xfer_fsm #(
    parameter int DEPTH_LOG2 = 8
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  go_store,
    input  logic                  go_recall,
    output logic                  busy,
    output logic                  do_store,
    output logic                  do_clear,
    output logic                  do_load,
    output logic [DEPTH_LOG2-1:0] ptr
);
    import nvs_pkg::*;
    localparam logic [DEPTH_LOG2-1:0] LAST = '1;

    xfer_state_t state_q, state_d;
    logic [DEPTH_LOG2-1:0] ptr_q;
    logic at_last;

    assign at_last = (ptr_q == LAST);

    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q <= XF_CLEAR;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= (state_q == XF_IDLE || at_last) ? '0 : ptr_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: begin
                if (go_store)       state_d = XF_STORE;
                else if (go_recall) state_d = XF_CLEAR;
            end
            XF_STORE: if (at_last) state_d = XF_IDLE;
            XF_CLEAR: if (at_last) state_d = XF_LOAD;
            XF_LOAD:  if (at_last) state_d = XF_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state_q != XF_IDLE);
        do_store = (state_q == XF_STORE);
        do_clear = (state_q == XF_CLEAR);
        do_load  = (state_q == XF_LOAD);
        ptr      = ptr_q;
    end

    assert_store_start_R3: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == XF_IDLE && go_store) |=> (state_q == XF_STORE && ptr_q == '0));
    assert_store_end_R3: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == XF_STORE && at_last) |=> (state_q == XF_IDLE));
    assert_clear_then_load_R4: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == XF_CLEAR && at_last) |=> (state_q == XF_LOAD && ptr_q == '0));
    assert_recall_start_R4: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == XF_IDLE && go_recall && !go_store) |=> (state_q == XF_CLEAR));
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
    parameter int DEPTH_LOG2 = 8,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  cs,
    input  logic                  oe,
    input  logic                  we,
    input  logic [DEPTH_LOG2-1:0] word,
    input  logic [DATA_W-1:0]     din,
    input  logic                  busy,
    input  logic                  do_store,
    input  logic                  do_clear,
    input  logic                  do_load,
    input  logic [DEPTH_LOG2-1:0] ptr,
    output logic [DATA_W-1:0]     dout,
    output logic                  dout_en
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    logic [DATA_W-1:0] work_mem   [DEPTH];
    logic [DATA_W-1:0] shadow_mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              en_q;
    logic              host_wr, host_rd;

    assign host_wr = cs && we && !busy;
    assign host_rd = cs && !we && !busy;

    always_ff @(posedge clk) begin
        if (do_clear)
            work_mem[ptr] <= '0;
        else if (do_load)
            work_mem[ptr] <= shadow_mem[ptr];
        else if (host_wr)
            work_mem[word] <= din;
    end

    always_ff @(posedge clk) begin
        if (do_store)
            shadow_mem[ptr] <= work_mem[ptr];
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            rd_q <= '0;
            en_q <= 1'b0;
        end else begin
            en_q <= host_rd && oe;
            if (host_rd)
                rd_q <= work_mem[word];
        end
    end

    assign dout    = en_q ? rd_q : '0;
    assign dout_en = en_q;

    assert_busy_silent_R7: assert property (@(posedge clk) disable iff (!por_n)
        busy |=> !dout_en);
    assert_no_oe_silent_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!oe || !cs) |=> !dout_en);
endmodule

// File: rtl/nvs_shadow_ram.sv
module nvs_shadow_ram #(
    parameter int          ADDR_W     = 15,
    parameter int          DEPTH_LOG2 = 8,
    parameter int          DATA_W     = 8,
    parameter logic [14:0] KEY0       = 15'h0E38,
    parameter logic [14:0] KEY1       = 15'h31C7,
    parameter logic [14:0] KEY2       = 15'h03E0,
    parameter logic [14:0] KEY3       = 15'h3C1F,
    parameter logic [14:0] KEY4       = 15'h303F,
    parameter logic [14:0] STORE_K    = 15'h0FC0,
    parameter logic [14:0] RECALL_K   = 15'h0C63
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              cs,
    input  logic              oe,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    logic go_store, go_recall;
    logic do_store, do_clear, do_load;
    logic [DEPTH_LOG2-1:0] ptr;

    nvs_key_watch #(
        .ADDR_W(ADDR_W), .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3),
        .KEY4(KEY4), .STORE_K(STORE_K), .RECALL_K(RECALL_K)
    ) u_watch (
        .clk(clk), .por_n(por_n), .cs(cs), .we(we), .busy(busy), .addr(addr),
        .go_store(go_store), .go_recall(go_recall)
    );

    nvs_xfer_fsm #(.DEPTH_LOG2(DEPTH_LOG2)) u_fsm (
        .clk(clk), .por_n(por_n), .go_store(go_store), .go_recall(go_recall),
        .busy(busy), .do_store(do_store), .do_clear(do_clear), .do_load(do_load),
        .ptr(ptr)
    );

    nvs_arrays #(.DEPTH_LOG2(DEPTH_LOG2), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .por_n(por_n), .cs(cs), .oe(oe), .we(we),
        .word(addr[DEPTH_LOG2-1:0]), .din(din), .busy(busy),
        .do_store(do_store), .do_clear(do_clear), .do_load(do_load), .ptr(ptr),
        .dout(dout), .dout_en(dout_en)
    );
endmodule

// File: tb/sim_nvs_shadow_ram.sv
`timescale 1ns/1ps
module sim_nvs_shadow_ram;
    localparam int AW = 15;
    localparam int DL = 5;
    localparam int D  = 1 << DL;
    localparam logic [14:0] K [6] = '{15'h0E38, 15'h31C7, 15'h03E0, 15'h3C1F, 15'h303F, 15'h0FC0};
    localparam logic [14:0] RK = 15'h0C63;

    logic clk = 1'b0, por_n = 1'b0, cs = 1'b0, oe = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0, dout;
    logic dout_en, busy;
    int total = 0, bad = 0, cyc = 0;
    logic [7:0] sram_m [D];
    logic [7:0] shad_m [D];

    always #2 clk = ~clk;

    nvs_shadow_ram #(.ADDR_W(AW), .DEPTH_LOG2(DL)) u0 (
        .clk(clk), .por_n(por_n), .cs(cs), .oe(oe), .we(we), .addr(addr),
        .din(din), .dout(dout), .dout_en(dout_en), .busy(busy));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [7:0] exp_word(input logic [AW-1:0] a);
        return sram_m[a[DL-1:0]];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs = 0; we = 0; oe = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        cs = 1; we = 1; oe = 0; addr = a; din = d;
        @(negedge clk);
        if (!busy || a == a) begin end
    endtask

    task automatic rd(input logic [AW-1:0] a, input bit o, output logic [7:0] d, output logic e);
        cs = 1; we = 0; oe = o; addr = a;
        @(negedge clk);
        d = dout; e = dout_en;
    endtask

    task automatic key_run(input logic [AW-1:0] last);
        logic [7:0] d; logic e;
        for (int i = 0; i < 5; i++) rd(K[i], 1'b1, d, e);
        rd(last, 1'b1, d, e);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        cs = 0; we = 0; oe = 0;
        while (busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_all(input string req);
        logic [7:0] d; logic e; int errs = 0; int first_a = 0, first_d = 0;
        for (int i = 0; i < D; i++) begin
            rd(AW'(i), 1'b1, d, e);
            if (!e || d !== sram_m[i]) begin
                if (errs == 0) begin first_a = i; first_d = d; end
                errs++;
            end
        end
        chk(errs == 0, req, first_d, sram_m[first_a]);
        idle();
    endtask

    task automatic fill_random();
        for (int i = 0; i < D; i++) begin
            logic [7:0] v = 8'($urandom);
            wr(AW'(i) | AW'($urandom_range(0, 1023) << DL), v);
            sram_m[i] = v;
        end
        idle();
    endtask

    initial begin
        logic [7:0] d; logic e; int n; int seed;
        seed = $urandom(32'd2024);
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R9 busy in reset", busy, 1);
        chk(dout_en == 1'b0, "R9 dout_en in reset", dout_en, 0);
        por_n = 1;
        count_busy(n);
        chk(n == 2 * D, "R9 power-up recall length", n, 2 * D);

        // R1: write/read and aliasing
        fill_random();
        check_all("R1 readback");
        wr(AW'(7) | AW'(3 << DL), 8'h5A); sram_m[7] = 8'h5A;
        rd(AW'(7) | AW'(9 << DL), 1'b1, d, e);
        chk(e && d == 8'h5A, "R1 alias", d, 8'h5A);
        // R2: no output without oe
        rd(AW'(7), 1'b0, d, e);
        chk(!e && d == 8'h00, "R2 oe low", {e, d}, 0);
        idle();
        chk(!dout_en, "R2 idle cycle", dout_en, 0);

        // R3 + R10: store
        key_run(K[5]);
        count_busy(n);
        chk(n == D, "R3 store length", n, D);
        for (int i = 0; i < D; i++) shad_m[i] = sram_m[i];

        // overwrite, then R4: recall restores
        fill_random();
        key_run(RK);
        count_busy(n);
        chk(n == 2 * D, "R4 recall length", n, 2 * D);
        for (int i = 0; i < D; i++) sram_m[i] = shad_m[i];
        check_all("R4 R10 recall contents");

        // R8: second recall after overwrite gives same shadow
        fill_random();
        key_run(RK);
        count_busy(n);
        for (int i = 0; i < D; i++) sram_m[i] = shad_m[i];
        check_all("R8 repeated recall");

        // R5: write aborts
        for (int i = 0; i < 3; i++) rd(K[i], 1'b1, d, e);
        wr(AW'(20), 8'h11); sram_m[20] = 8'h11;
        for (int i = 3; i < 6; i++) rd(K[i], 1'b1, d, e);
        chk(!busy, "R5 write abort", busy, 0);
        // R5: mismatching read, even when it is the first key, is not a restart
        for (int i = 0; i < 4; i++) rd(K[i], 1'b1, d, e);
        rd(K[0], 1'b1, d, e);
        for (int i = 1; i < 6; i++) rd(K[i], 1'b1, d, e);
        chk(!busy, "R5 no restart on mismatch", busy, 0);
        // R11: wrong sixth address
        key_run(15'h1234);
        chk(!busy, "R11 bad selector", busy, 0);
        key_run(K[5]);
        chk(busy, "R11 restart works", busy, 1);
        count_busy(n);
        for (int i = 0; i < D; i++) shad_m[i] = sram_m[i];

        // R6: deselected cycles inside the sequence
        fill_random();
        for (int i = 0; i < 5; i++) begin rd(K[i], 1'b1, d, e); idle(); end
        rd(RK, 1'b1, d, e);
        chk(busy, "R6 deselect tolerated", busy, 1);
        count_busy(n);
        for (int i = 0; i < D; i++) sram_m[i] = shad_m[i];
        check_all("R6 recall after gaps");

        // R7: accesses during busy
        key_run(K[5]);
        wr(AW'(3), ~sram_m[3]);
        rd(AW'(3), 1'b1, d, e);
        chk(!e, "R7 no read during busy", e, 0);
        key_run(RK);
        chk(!dout_en, "R7 key reads silent", dout_en, 0);
        count_busy(n);
        idle();
        chk(!busy, "R7 no command latched in busy", busy, 0);
        rd(AW'(3), 1'b1, d, e);
        chk(e && d == exp_word(AW'(3)), "R7 write ignored", d, exp_word(AW'(3)));
        idle();
        for (int i = 0; i < D; i++) shad_m[i] = sram_m[i];

        // R9: power cycle preserves shadow
        fill_random();
        por_n = 0;
        repeat (2) @(negedge clk);
        chk(busy && !dout_en, "R9 reset again", {busy, dout_en}, 2);
        por_n = 1;
        count_busy(n);
        chk(n == 2 * D, "R9 recall after reset", n, 2 * D);
        for (int i = 0; i < D; i++) sram_m[i] = shad_m[i];
        check_all("R9 contents kept");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule